// File: doc/BRIEF.md
# Table-Driven Byte CRC Engine

This block updates a 16-bit cyclic redundancy value one message byte at a time. It does not hard-wire a polynomial. Instead it keeps a writable correction table with one 16-bit word for each of the 256 possible index bytes. A host first fills the table through a simple write port. It then streams message bytes into the engine. For each byte, the engine forms an index from the byte and the low half of the running value, shifts the running value right by one byte, and XORs in the table word at that index. Any reflected 16-bit CRC can be computed by loading the matching table. The update sequence stays the same for every polynomial.

Bytes enter through a valid/ready interface. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The producer must keep `in_valid` and `in_data` stable until that edge. `in_ready` is low in four cases: during the update cycle that follows each accepted byte, while a table write is presented, while a clear is presented, and during reset. The table read is registered, so each byte takes two cycles. The first cycle captures the index and the second applies the update. The new value appears on `crc_out` after the second edge. A synchronous clear sets the running value to zero and leaves the table contents unchanged.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, `crc_out` is 0x0000, `busy` is 0 and `in_ready` is 1 (provided `tbl_we` and `clear` are low).
- R2: The table index for an accepted byte is `in_data` XOR `crc_out[7:0]`, using the value of `crc_out` at the accepting edge.
- R3: On the second edge after acceptance, `crc_out` becomes (previous `crc_out` >> 8) XOR T[index], where T[i] is the word last written to table address i.
- R4: On the edge after an accepted byte, `busy` goes to 1 for exactly one cycle. While `busy` is 1, `in_ready` is 0, so no second byte can be accepted until the update finishes.
- R5: While `tbl_we` is 1, `in_ready` is 0. A byte held valid during a table write is stalled and is accepted afterwards, with no loss.
- R6: While `clear` is 1, `in_ready` is 0, and on the next edge `crc_out` becomes 0x0000. The table contents are preserved.
- R7: A clear presented in the `busy` cycle cancels that pending update: `crc_out` is 0x0000 after the edge.
- R8: When no update or clear occurs, `crc_out` holds its value.
- R9: With the reflected CRC-16 table loaded (reversed polynomial 0xA001) and `crc_out` at zero, one byte b gives T[b]. In hex, the expected values are 0→0000, 1→C0C1, 2→C181, 4→C301, 8→C601, 16→CC01, 128→A001 and 255→4040.
- R10: Loading a table built for a different reflected polynomial (reversed 0x8408) changes the result with no other change. The running value then matches a bit-serial reference for that polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous clear of the running CRC value |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address |
| tbl_wdata | input | 16 | Table write data |
| in_valid | input | 1 | Message byte valid |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Engine can accept a byte this cycle |
| busy | output | 1 | Update cycle in progress |
| crc_out | output | 16 | Running CRC value |

## Verification
On every cycle, the assertions check the handshake rules. A table write, a clear or a busy cycle must each hold `in_ready` low. An acceptance must produce exactly one busy cycle. A clear must zero the value on the next edge. `crc_out` must hold when neither an update nor a clear occurs. Whether the value is arithmetically correct can only be shown by the bench's scenarios. These compare the engine against a bit-serial reference over random messages for two polynomials, check the fixed table values, and check stalled bytes and cancelled updates.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_UPD  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/crc_lut_ram.sv
module crc_lut_ram #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port; word is valid the cycle after rd_en.
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/crc_byte_ctrl.sv
module crc_byte_ctrl
  import crc_eng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tbl_we,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic upd_en,
  output logic busy
);
  eng_state_t state_q, state_d;

  assign in_ready = (state_q == ST_IDLE) && !tbl_we && !clear && rst_n;
  assign accept   = in_valid && in_ready;
  assign busy     = (state_q == ST_UPD);
  // A clear during the update cycle cancels the update.
  assign upd_en   = busy && !clear;

  always_comb begin
    state_d = state_q;
    if (clear)        state_d = ST_IDLE;
    else if (accept)  state_d = ST_UPD;
    else if (busy)    state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/crc_update_dp.sv
module crc_update_dp #(
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd_en,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [CRC_W-1:0]  tbl_word,
  output logic [BYTE_W-1:0] index,
  output logic [CRC_W-1:0]  crc_q
);
  // Low byte of the running value folded with the incoming byte.
  assign index = byte_in ^ crc_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= '0;
    else if (clear)  crc_q <= '0;
    else if (upd_en) crc_q <= (crc_q >> BYTE_W) ^ tbl_word;
  end
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tbl_we,
  input  logic [BYTE_W-1:0] tbl_addr,
  input  logic [CRC_W-1:0]  tbl_wdata,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic [CRC_W-1:0]  crc_out
);
  logic              accept;
  logic              upd_en;
  logic [BYTE_W-1:0] index;
  logic [CRC_W-1:0]  tbl_word;

  crc_byte_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tbl_we   (tbl_we),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .upd_en   (upd_en),
    .busy     (busy)
  );

  crc_lut_ram #(.ADDR_W(BYTE_W), .WORD_W(CRC_W)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_en   (accept),
    .rd_addr (index),
    .rd_data (tbl_word)
  );

  crc_update_dp #(.BYTE_W(BYTE_W), .CRC_W(CRC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .upd_en   (upd_en),
    .byte_in  (in_data),
    .tbl_word (tbl_word),
    .index    (index),
    .crc_q    (crc_out)
  );
endmodule

// File: rtl/crc_byte_engine_chk.sv
module crc_byte_engine_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             tbl_we,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic [CRC_W-1:0] crc_out
);
  assert_tbl_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !in_ready);

  assert_clear_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == '0));

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clear) |=> $stable(crc_out));
endmodule

bind crc_byte_engine crc_byte_engine_chk #(.CRC_W(CRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .tbl_we   (tbl_we),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .crc_out  (crc_out)
);

// File: tb/sim_crc_byte_engine.sv
`timescale 1ns/1ps
module sim_crc_byte_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        busy;
  logic [15:0] crc_out;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  crc_byte_engine u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .busy(busy), .crc_out(crc_out)
  );

  function automatic logic [15:0] tbl_val(input logic [15:0] poly, input logic [7:0] idx);
    logic [15:0] r;
    r = {8'h00, idx};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      r = (r[0] ^ b[k]) ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [15:0] poly);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = i[7:0]; tbl_wdata = tbl_val(poly, i[7:0]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    #1 check("R6 ready low in clear", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    clear = 1'b0;
    check("R6 clear zero", crc_out, 16'h0000);
  endtask

  // Sends one byte; returns at a negedge with the result on crc_out.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 busy in update cycle", {14'd0, busy, in_ready}, 16'h0002);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  logic [15:0] exp_crc;
  logic [7:0]  keep;
  logic [7:0]  idx_list [8] = '{8'd0, 8'd1, 8'd2, 8'd4, 8'd8, 8'd16, 8'd128, 8'd255};
  logic [15:0] val_list [8] = '{16'h0000, 16'hC0C1, 16'hC181, 16'hC301,
                                16'hC601, 16'hCC01, 16'hA001, 16'h4040};

  initial begin
    void'($urandom(32'h5EED_0C0C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 crc after reset", crc_out, 16'h0000);
    check("R1 ready/busy after reset", {14'd0, busy, in_ready}, 16'h0001);

    load_table(16'hA001);

    // R9 fixed entries of the reflected CRC-16 table
    for (int i = 0; i < 8; i++) begin
      do_clear();
      send(idx_list[i]);
      check("R9 table value", crc_out, val_list[i]);
    end

    // R2/R3 index uses low byte of running value: nonzero start
    do_clear();
    send(8'h01);               // crc = C0C1
    send(8'hC1);               // index = C1^C1 = 0 -> (C0C1>>8)^0000
    check("R2 index fold", crc_out, 16'h00C0);

    // R8 hold with no traffic
    repeat (5) @(negedge clk);
    check("R8 hold idle", crc_out, 16'h00C0);

    // R3 random messages vs bit-serial reference, random idle gaps
    for (int m = 0; m < 20; m++) begin
      int len;
      do_clear();
      exp_crc = 16'h0000;
      len = 1 + ($urandom % 12);
      for (int j = 0; j < len; j++) begin
        logic [7:0] b;
        b = 8'($urandom);
        send(b);
        exp_crc = ref_step(exp_crc, b, 16'hA001);
        repeat ($urandom % 3) @(negedge clk);
      end
      check("R3 message crc", crc_out, exp_crc);
    end

    // R5 byte stalled by table write (rewrite same word)
    do_clear();
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'h37; tbl_wdata = tbl_val(16'hA001, 8'h37);
    in_valid = 1'b1; in_data = 8'h37;
    #1 check("R5 ready low in write", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    tbl_we = 1'b0;
    @(negedge clk);            // byte accepted at edge just passed
    in_valid = 1'b0;
    check("R5 busy after stall", {15'd0, busy}, 16'd1);
    @(negedge clk);
    check("R5 stalled byte", crc_out, tbl_val(16'hA001, 8'h37));

    // R7 clear in busy cycle cancels the update
    send(8'h55);
    keep = 8'h9A;
    @(negedge clk);
    in_valid = 1'b1; in_data = keep;
    @(negedge clk);            // accepted; now busy
    in_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R7 cancel update", crc_out, 16'h0000);
    check("R7 busy cleared", {15'd0, busy}, 16'd0);

    // R6 table intact after clears
    send(8'h01);
    check("R6 table preserved", crc_out, 16'hC0C1);

    // R10 different polynomial by table reload only
    load_table(16'h8408);
    for (int m = 0; m < 8; m++) begin
      int len;
      do_clear();
      exp_crc = 16'h0000;
      len = 1 + ($urandom % 10);
      for (int j = 0; j < len; j++) begin
        logic [7:0] b;
        b = 8'($urandom);
        send(b);
        exp_crc = ref_step(exp_crc, b, 16'h8408);
      end
      check("R10 reloaded polynomial", crc_out, exp_crc);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule